// File: doc/BRIEF.md
# Sector Protection and Lockdown Controller

This block keeps the write-protection state of a serial flash array that is divided into equal 64-Kbyte sectors. Each sector has two bits. One is a protection bit that software can set and clear. The other is a lockdown bit that, once set, never clears. The command front end hands the block one decoded command per cycle, together with a sector number and, for status writes, a data byte. The block also receives the write-enable latch state, the level of the write-protect pin and whether a program or erase is currently suspended.

The block decides whether each command takes effect. It updates the sector bits and the protection-related status bits (the software lock bit, the lockdown-enable bit and the frozen flag). For every write-class command that arrives with the write-enable latch set, it asks the front end to clear the latch. Before a program or erase, the front end sends a check command, and the block answers with a permit or failure pulse. A two-bit summary reports whether none, some or all sectors are protected.

Top module: `sector_guard`

## Requirements
- R1: After reset every sector is protected and none is locked down, the software lock, lockdown-enable and frozen bits are 0, and the summary reads 11.
- R2: Op 1 protects and op 2 unprotects the addressed sector when the write-enable input is 1 and the software lock bit is 0, and they are rejected while the software lock is 1. Every write-class command (ops 1 to 6) given with write-enable 1 pulses `wel_clear` one cycle later. Any command given with write-enable 0 changes nothing and gives no pulse.
- R3: Op 5 is a status write while the software lock is 0. Data bit 7 becomes the software lock bit. A data field bits 5..2 of 1111 protects all sectors, 0000 unprotects all sectors, and any other value leaves the sectors alone, so FFh sets the lock and protects everything in one step.
- R4: While the software lock is 1 and the write-protect input is 1, op 5 is ignored entirely, including any attempt to clear the lock.
- R5: While the software lock is 1 and the write-protect input is 0, op 5 only updates the lock bit from data bit 7. The global field is not applied.
- R6: While the suspend input is 1, an op 5 that would protect or unprotect all sectors is aborted with no change at all. An op 5 whose global field has no effect still updates the lock bit.
- R7: Op 6 loads the lockdown-enable bit from data bit 4, and it is ignored once the frozen flag is 1.
- R8: Op 3 sets the addressed sector's lockdown bit only while lockdown-enable is 1 and the frozen flag is 0. A lockdown bit is never cleared.
- R9: Op 4 (freeze) with lockdown-enable 1, frozen 0 and suspend 0 sets the frozen flag and clears lockdown-enable. Otherwise it aborts and leaves lockdown-enable as it was.
- R10: Op 7 (program/erase check) pulses `resp_valid` one cycle later. `permit` is 1 exactly when the sector is neither protected nor locked down, and `pe_fail` is its inverse.
- R11: Op 8 (query) loads `rd_prot` and `rd_lock` with the addressed sector's bits one cycle later, and they hold until the next query.
- R12: `prot_sum` reads 00 when no sector is protected, 01 when some are and 11 when all are, two cycles after the command that changed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cmd_valid | input | 1 | command present this cycle |
| cmd_op | input | 4 | decoded command code (0 none, 1..8 as in requirements) |
| cmd_sector | input | $clog2(NUM_SECT) | addressed sector |
| cmd_data | input | 8 | status write byte |
| wel | input | 1 | write-enable latch state |
| hw_wp | input | 1 | write-protect pin asserted |
| suspended | input | 1 | a program or erase is suspended |
| wel_clear | output | 1 | request to clear the write-enable latch |
| resp_valid | output | 1 | check answer valid |
| permit | output | 1 | program/erase allowed |
| pe_fail | output | 1 | program/erase refused |
| rd_prot | output | 1 | queried sector protection bit |
| rd_lock | output | 1 | queried sector lockdown bit |
| sprl | output | 1 | software lock bit |
| sle | output | 1 | lockdown-enable bit |
| frozen | output | 1 | lockdown state frozen |
| prot_sum | output | 2 | none/some/all protected summary |

## Verification
The bench builds the block with NUM_SECT = 8, so a sweep of the 3-bit sector field visits every sector with every query and check. With only eight sectors, sector-by-sector unprotect walks the summary through all three of its codes in a handful of commands. Every combination of the software lock, write-protect and suspend inputs that the status-write rules distinguish is reached, and so is every freeze and lockdown gating case.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_PROT   = 4'd1,
    OP_UNPROT = 4'd2,
    OP_LOCK   = 4'd3,
    OP_FREEZE = 4'd4,
    OP_WRST1  = 4'd5,
    OP_WRST2  = 4'd6,
    OP_CHECK  = 4'd7,
    OP_QUERY  = 4'd8
  } sg_op_e;

  typedef struct packed {
    logic set_prot;
    logic clr_prot;
    logic set_lock;
    logic glob_prot;
    logic glob_unprot;
    logic sprl_we;
    logic sprl_d;
    logic sle_we;
    logic sle_d;
    logic freeze;
    logic wel_clr;
  } sg_act_t;
endpackage

// File: rtl/sg_cmd_eval.sv
module sg_cmd_eval
  import sg_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] op,
  input  logic [7:0] data,
  input  logic       wel,
  input  logic       wp,
  input  logic       susp,
  input  logic       sprl,
  input  logic       sle,
  input  logic       frozen,
  output sg_act_t    act
);
  logic wr_class;
  logic glob_ones;
  logic glob_zero;
  logic unused_bits;

  assign wr_class    = (op >= 4'(OP_PROT)) && (op <= 4'(OP_WRST2));
  assign glob_ones   = (data[5:2] == 4'hF);
  assign glob_zero   = (data[5:2] == 4'h0);
  assign unused_bits = ^{data[6], data[1:0]};

  always_comb begin
    act = '0;
    if (valid && wel && wr_class) begin
      act.wel_clr = 1'b1;
      case (sg_op_e'(op))
        OP_PROT:   act.set_prot = !sprl;
        OP_UNPROT: act.clr_prot = !sprl;
        OP_LOCK:   act.set_lock = sle && !frozen;
        OP_FREEZE: act.freeze   = sle && !frozen && !susp;
        OP_WRST1: begin
          if (sprl) begin
            if (!wp && !data[7]) begin
              act.sprl_we = 1'b1;
              act.sprl_d  = 1'b0;
            end
          end else if (!(susp && (glob_ones || glob_zero))) begin
            act.sprl_we     = 1'b1;
            act.sprl_d      = data[7];
            act.glob_prot   = glob_ones;
            act.glob_unprot = glob_zero;
          end
        end
        OP_WRST2: begin
          if (!frozen) begin
            act.sle_we = 1'b1;
            act.sle_d  = data[4];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sg_sector_bits.sv
module sg_sector_bits #(
  parameter int N  = 128,
  parameter int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sel,
  input  logic          set_prot,
  input  logic          clr_prot,
  input  logic          set_lock,
  input  logic          glob_prot,
  input  logic          glob_unprot,
  output logic [N-1:0]  prot,
  output logic [N-1:0]  lock
);
  for (genvar i = 0; i < N; i++) begin : g_sect
    logic p_q;
    logic l_q;
    logic hit;
    assign hit = (sel == SW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        p_q <= 1'b1;
        l_q <= 1'b0;
      end else begin
        if (glob_prot)             p_q <= 1'b1;
        else if (glob_unprot)      p_q <= 1'b0;
        else if (hit && set_prot)  p_q <= 1'b1;
        else if (hit && clr_prot)  p_q <= 1'b0;
        if (hit && set_lock)       l_q <= 1'b1;
      end
    end

    assign prot[i] = p_q;
    assign lock[i] = l_q;
  end
endmodule

// File: rtl/sg_summary.sv
module sg_summary #(
  parameter int N = 128
) (
  input  logic [N-1:0] prot,
  output logic [1:0]   sum
);
  logic all_set;
  logic none_set;
  assign all_set  = &prot;
  assign none_set = ~|prot;
  assign sum = all_set ? 2'b11 : (none_set ? 2'b00 : 2'b01);
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int NUM_SECT = 128,
  localparam int SW = $clog2(NUM_SECT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [SW-1:0] cmd_sector,
  input  logic [7:0]    cmd_data,
  input  logic          wel,
  input  logic          hw_wp,
  input  logic          suspended,
  output logic          wel_clear,
  output logic          resp_valid,
  output logic          permit,
  output logic          pe_fail,
  output logic          rd_prot,
  output logic          rd_lock,
  output logic          sprl,
  output logic          sle,
  output logic          frozen,
  output logic [1:0]    prot_sum
);
  sg_act_t             act;
  logic [NUM_SECT-1:0] prot_v;
  logic [NUM_SECT-1:0] lock_v;
  logic [1:0]          sum_c;
  logic                sect_free;
  logic                is_check;
  logic                is_query;

  sg_cmd_eval u_eval (
    .valid (cmd_valid),
    .op    (cmd_op),
    .data  (cmd_data),
    .wel   (wel),
    .wp    (hw_wp),
    .susp  (suspended),
    .sprl  (sprl),
    .sle   (sle),
    .frozen(frozen),
    .act   (act)
  );

  sg_sector_bits #(.N(NUM_SECT), .SW(SW)) u_bits (
    .clk        (clk),
    .rst        (rst),
    .sel        (cmd_sector),
    .set_prot   (act.set_prot),
    .clr_prot   (act.clr_prot),
    .set_lock   (act.set_lock),
    .glob_prot  (act.glob_prot),
    .glob_unprot(act.glob_unprot),
    .prot       (prot_v),
    .lock       (lock_v)
  );

  sg_summary #(.N(NUM_SECT)) u_sum (
    .prot(prot_v),
    .sum (sum_c)
  );

  assign sect_free = !prot_v[cmd_sector] && !lock_v[cmd_sector];
  assign is_check  = cmd_valid && (cmd_op == 4'(OP_CHECK));
  assign is_query  = cmd_valid && (cmd_op == 4'(OP_QUERY));

  always_ff @(posedge clk) begin
    if (rst) begin
      sprl       <= 1'b0;
      sle        <= 1'b0;
      frozen     <= 1'b0;
      wel_clear  <= 1'b0;
      resp_valid <= 1'b0;
      permit     <= 1'b0;
      pe_fail    <= 1'b0;
      rd_prot    <= 1'b0;
      rd_lock    <= 1'b0;
      prot_sum   <= 2'b11;
    end else begin
      if (act.sprl_we) sprl <= act.sprl_d;
      if (act.freeze) begin
        frozen <= 1'b1;
        sle    <= 1'b0;
      end else if (act.sle_we) begin
        sle <= act.sle_d;
      end
      wel_clear  <= act.wel_clr;
      resp_valid <= is_check;
      permit     <= is_check && sect_free;
      pe_fail    <= is_check && !sect_free;
      if (is_query) begin
        rd_prot <= prot_v[cmd_sector];
        rd_lock <= lock_v[cmd_sector];
      end
      prot_sum <= sum_c;
    end
  end
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
  parameter int N = 128
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_valid,
  input logic         wel,
  input logic         hw_wp,
  input logic         wel_clear,
  input logic         permit,
  input logic         pe_fail,
  input logic         sprl,
  input logic         sle,
  input logic         frozen,
  input logic [1:0]   prot_sum,
  input logic [N-1:0] lock_v
);
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(lock_v) & ~lock_v) == '0));

  a_r4_hw_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (sprl && hw_wp) |=> sprl);

  a_r9_freeze_sticky: assert property (@(posedge clk) disable iff (rst)
    frozen |=> frozen);

  a_r7_frozen_no_sle: assert property (@(posedge clk) disable iff (rst)
    frozen |-> !sle);

  a_r2_welclr_cause: assert property (@(posedge clk) disable iff (rst)
    wel_clear |-> $past(cmd_valid && wel));

  a_r10_permit_excl: assert property (@(posedge clk) disable iff (rst)
    !(permit && pe_fail));

  a_r12_sum_code: assert property (@(posedge clk) disable iff (rst)
    prot_sum != 2'b10);
endmodule

bind sector_guard sg_guard_chk #(.N(NUM_SECT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .wel      (wel),
  .hw_wp    (hw_wp),
  .wel_clear(wel_clear),
  .permit   (permit),
  .pe_fail  (pe_fail),
  .sprl     (sprl),
  .sle      (sle),
  .frozen   (frozen),
  .prot_sum (prot_sum),
  .lock_v   (lock_v)
);

// File: tb/tb_sector_guard.sv
module tb_sector_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          cmd_valid;
  logic [3:0]    cmd_op;
  logic [SW-1:0] cmd_sector;
  logic [7:0]    cmd_data;
  logic          wel, hw_wp, suspended;
  logic          wel_clear, resp_valid, permit, pe_fail, rd_prot, rd_lock;
  logic          sprl, sle, frozen;
  logic [1:0]    prot_sum;

  int checks = 0;
  int errors = 0;

  bit m_prot [NS];
  bit m_lock [NS];
  bit m_sprl, m_sle, m_frz;

  sector_guard #(.NUM_SECT(NS)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_data(cmd_data), .wel(wel), .hw_wp(hw_wp),
    .suspended(suspended), .wel_clear(wel_clear), .resp_valid(resp_valid),
    .permit(permit), .pe_fail(pe_fail), .rd_prot(rd_prot), .rd_lock(rd_lock),
    .sprl(sprl), .sle(sle), .frozen(frozen), .prot_sum(prot_sum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int exp_sum();
    int n = 0;
    for (int i = 0; i < NS; i++) n += int'(m_prot[i]);
    if (n == NS) return 3;
    if (n == 0) return 0;
    return 1;
  endfunction

  task automatic cmd(input int op, input int sec, input int data, input bit w,
                     input bit wp, input bit su, input string rq);
    bit exp_clr, gf, gz, e_perm, e_p, e_l;
    exp_clr = w && op >= 1 && op <= 6;
    gf = ((data >> 2) & 15) == 15;
    gz = ((data >> 2) & 15) == 0;
    e_p = m_prot[sec];
    e_l = m_lock[sec];
    e_perm = !e_p && !e_l;
    if (w) begin
      case (op)
        1: if (!m_sprl) m_prot[sec] = 1'b1;
        2: if (!m_sprl) m_prot[sec] = 1'b0;
        3: if (m_sle && !m_frz) m_lock[sec] = 1'b1;
        4: if (m_sle && !m_frz && !su) begin m_frz = 1'b1; m_sle = 1'b0; end
        5: begin
          if (m_sprl) begin
            if (!wp && data[7] == 1'b0) m_sprl = 1'b0;
          end else if (!(su && (gf || gz))) begin
            m_sprl = data[7];
            for (int i = 0; i < NS; i++) begin
              if (gf) m_prot[i] = 1'b1;
              if (gz) m_prot[i] = 1'b0;
            end
          end
        end
        6: if (!m_frz) m_sle = data[4];
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_sector = SW'(sec);
    cmd_data = 8'(data); wel = w; hw_wp = wp; suspended = su;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({rq, " wel_clear"}, int'(wel_clear), int'(exp_clr));
    check({rq, " sprl"}, int'(sprl), int'(m_sprl));
    check({rq, " sle"}, int'(sle), int'(m_sle));
    check({rq, " frozen"}, int'(frozen), int'(m_frz));
    if (op == 7) begin
      check("R10 resp_valid", int'(resp_valid), 1);
      check("R10 permit", int'(permit), int'(e_perm));
      check("R10 pe_fail", int'(pe_fail), int'(!e_perm));
    end
    if (op == 8) begin
      check("R11 rd_prot", int'(rd_prot), int'(e_p));
      check("R11 rd_lock", int'(rd_lock), int'(e_l));
    end
    @(negedge clk);
    check("R12 prot_sum", int'(prot_sum), exp_sum());
    check("R10 resp_valid drop", int'(resp_valid), 0);
  endtask

  task automatic sweep(input string rq);
    for (int s = 0; s < NS; s++) begin
      cmd(8, s, 0, 1'b0, 1'b0, 1'b0, rq);
      cmd(7, s, 0, 1'b0, 1'b0, 1'b0, rq);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_sector = '0;
    cmd_data = '0; wel = 1'b0; hw_wp = 1'b0; suspended = 1'b0;
    for (int i = 0; i < NS; i++) begin m_prot[i] = 1'b1; m_lock[i] = 1'b0; end
    m_sprl = 1'b0; m_sle = 1'b0; m_frz = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 sum", int'(prot_sum), 3);
    check("R1 sprl", int'(sprl), 0);
    check("R1 sle", int'(sle), 0);
    check("R1 frozen", int'(frozen), 0);
    check("R1 wel_clear", int'(wel_clear), 0);
    sweep("R1");
    // R2 unprotect each sector, summary walks 11 -> 01 -> 00 (R12)
    for (int s = 0; s < NS; s++) cmd(2, s, 0, 1'b1, 1'b0, 1'b0, "R2");
    cmd(1, 3, 0, 1'b0, 1'b0, 1'b0, "R2 no wel");
    cmd(1, 2, 0, 1'b1, 1'b0, 1'b0, "R2");
    cmd(1, 5, 0, 1'b1, 1'b0, 1'b0, "R2");
    sweep("R10");
    // R3 global field
    cmd(5, 0, 8'h3C, 1'b1, 1'b0, 1'b0, "R3");
    cmd(5, 0, 8'h00, 1'b1, 1'b0, 1'b0, "R3");
    cmd(5, 0, 8'h14, 1'b1, 1'b0, 1'b0, "R3");
    cmd(1, 6, 0, 1'b1, 1'b0, 1'b0, "R2");
    cmd(5, 0, 8'h14, 1'b1, 1'b0, 1'b0, "R3 partial");
    cmd(5, 0, 8'hFF, 1'b1, 1'b0, 1'b0, "R3 FFh");
    cmd(2, 1, 0, 1'b1, 1'b0, 1'b0, "R2 locked");
    sweep("R2");
    // R4 hardware lock
    cmd(5, 0, 8'h00, 1'b1, 1'b1, 1'b0, "R4");
    // R5 software lock: only the lock bit changes
    cmd(5, 0, 8'h00, 1'b1, 1'b0, 1'b0, "R5");
    // R6 suspend
    cmd(5, 0, 8'h00, 1'b1, 1'b0, 1'b1, "R6");
    cmd(5, 0, 8'h84, 1'b1, 1'b0, 1'b1, "R6");
    cmd(5, 0, 8'h04, 1'b1, 1'b0, 1'b0, "R6");
    cmd(5, 0, 8'h00, 1'b1, 1'b0, 1'b0, "R3");
    // R8 lockdown gated by enable
    cmd(3, 4, 0, 1'b1, 1'b0, 1'b0, "R8 no sle");
    cmd(6, 0, 8'h10, 1'b1, 1'b0, 1'b0, "R7");
    cmd(3, 4, 0, 1'b1, 1'b0, 1'b0, "R8");
    cmd(2, 4, 0, 1'b1, 1'b0, 1'b0, "R8");
    sweep("R8");
    // R9 freeze
    cmd(4, 0, 0, 1'b1, 1'b0, 1'b1, "R9 susp");
    cmd(4, 0, 0, 1'b0, 1'b0, 1'b0, "R9 no wel");
    cmd(4, 0, 0, 1'b1, 1'b0, 1'b0, "R9");
    cmd(4, 0, 0, 1'b1, 1'b0, 1'b0, "R9 again");
    cmd(6, 0, 8'h10, 1'b1, 1'b0, 1'b0, "R7 frozen");
    cmd(3, 6, 0, 1'b1, 1'b0, 1'b0, "R8 frozen");
    cmd(5, 0, 8'h3C, 1'b1, 1'b0, 1'b0, "R3");
    cmd(5, 0, 8'h00, 1'b1, 1'b0, 1'b0, "R3");
    sweep("R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule